// File: doc/BRIEF.md
# Miss Status Holding Register File

This block keeps track of the load misses that a non-blocking data cache has sent to memory while an in-order pipeline keeps running. Each entry stands for one whole cache line being fetched. For every word of that line it records the destination register, if one is waiting. A miss to a line that is not yet outstanding takes a free entry and produces one memory request. A miss to a line that is already outstanding joins the existing entry and produces no request. A load that is accepted leaves the pipeline at once, and its destination register is marked busy (empty).

When memory returns the line, with the entry index as its tag, the block writes back the waiting registers one per cycle, in ascending word order. Each register is marked full again as it is written, and the entry is freed after its last waiting word. Decode reads the busy vector and holds any instruction that reads a busy register. A miss that the block cannot take is refused with a stall in the same cycle and leaves no trace.

Top module: `mshr_file`

## Requirements
- R1: An accepted miss whose line matches no outstanding unfilled entry takes the lowest-numbered free entry, queues one memory request carrying the line address with that entry index as tag, and sets the busy bit of its destination register in the following cycle.
- R2: An accepted miss whose line matches an entry that is waiting for its fill is merged into that entry and creates no new memory request.
- R3: A miss that matches a waiting entry on a word that already has a waiting register is stalled and not accepted.
- R4: A miss that matches no waiting entry while every entry is busy is stalled and not accepted.
- R5: A miss whose destination register is already busy is stalled and not accepted.
- R6: Memory requests leave in allocation order through a valid/ready handshake, and a request stays valid with an unchanged tag and line while ready is low.
- R7: After a fill for an entry, the registers waiting on that entry are written back one per consecutive cycle in ascending word order, and each write-back carries the fill word at that offset (word w in bits w*32 upward of the fill bus).
- R8: A write-back clears its register's busy bit in the same cycle, and the entry is free for a new line after its last write-back.
- R9: After reset no register is busy, no request is valid and no write-back is valid.
- R10: A stalled miss changes no state: it sets no busy bit and queues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | A load miss is presented |
| miss_line | input | LINE_W (28) | Line address of the miss |
| miss_word | input | log2(N_WORDS) (2) | Word offset within the line |
| miss_rd | input | log2(N_REGS) (5) | Destination register of the load |
| miss_stall | output | 1 | The presented miss is refused this cycle |
| reg_busy | output | N_REGS (32) | Per-register empty bit, 1 while a load to it is outstanding |
| req_valid | output | 1 | A memory request is offered |
| req_ready | input | 1 | Memory takes the offered request |
| req_line | output | LINE_W (28) | Line address of the request |
| req_tag | output | log2(N_ENT) (2) | Entry index tagging the request |
| fill_valid | input | 1 | A line fill arrives |
| fill_tag | input | log2(N_ENT) (2) | Entry index the fill belongs to |
| fill_data | input | N_WORDS*DATA_W (128) | The whole line, word w in bits w*DATA_W upward |
| wb_valid | output | 1 | A register write-back is presented |
| wb_rd | output | log2(N_REGS) (5) | Register being written |
| wb_data | output | DATA_W (32) | Data written to the register |

## Verification
Checked every cycle by the bound checker: a busy destination always stalls, an accepted miss leaves its register busy, a refused miss leaves a non-busy register untouched, a write-back register is no longer busy, and a request waiting on ready holds its tag and line. Only the bench scenarios can show that merges create no extra request, that requests drain in allocation order, that write-backs follow ascending word order with the right fill words in back-to-back cycles, and that a freed entry is reused for a new line.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  typedef enum logic [1:0] {
    ENT_FREE   = 2'd0,
    ENT_WAIT   = 2'd1,
    ENT_FILLED = 2'd2
  } ent_state_t;
endpackage

// File: rtl/mshr_prio_enc.sv
module mshr_prio_enc #(
  parameter int W = 4
) (
  input  logic [W-1:0]         vec,
  output logic [$clog2(W)-1:0] idx,
  output logic                 any
);
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = $clog2(W)'(i);
    end
    any = |vec;
  end
endmodule

// File: rtl/mshr_order_fifo.sv
module mshr_order_fifo #(
  parameter int DEPTH = 4,
  parameter int DW    = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic          not_empty,
  output logic [DW-1:0] head
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] slot [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) slot[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  assign not_empty = (count != '0);
  assign head      = slot[rd_ptr];
endmodule

// File: rtl/mshr_scoreboard.sv
module mshr_scoreboard #(
  parameter int N_REGS = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      set_en,
  input  logic [$clog2(N_REGS)-1:0] set_idx,
  input  logic                      clr_en,
  input  logic [$clog2(N_REGS)-1:0] clr_idx,
  output logic [N_REGS-1:0]         busy
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= '0;
    end else begin
      if (clr_en) busy[clr_idx] <= 1'b0;
      if (set_en) busy[set_idx] <= 1'b1;
    end
  end
endmodule

// File: rtl/mshr_file.sv
module mshr_file #(
  parameter int N_ENT   = 4,
  parameter int N_WORDS = 4,
  parameter int N_REGS  = 32,
  parameter int LINE_W  = 28,
  parameter int DATA_W  = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         miss_valid,
  input  logic [LINE_W-1:0]            miss_line,
  input  logic [$clog2(N_WORDS)-1:0]   miss_word,
  input  logic [$clog2(N_REGS)-1:0]    miss_rd,
  output logic                         miss_stall,
  output logic [N_REGS-1:0]            reg_busy,
  output logic                         req_valid,
  input  logic                         req_ready,
  output logic [LINE_W-1:0]            req_line,
  output logic [$clog2(N_ENT)-1:0]     req_tag,
  input  logic                         fill_valid,
  input  logic [$clog2(N_ENT)-1:0]     fill_tag,
  input  logic [N_WORDS*DATA_W-1:0]    fill_data,
  output logic                         wb_valid,
  output logic [$clog2(N_REGS)-1:0]    wb_rd,
  output logic [DATA_W-1:0]            wb_data
);
  import mshr_pkg::*;

  localparam int TAG_W = $clog2(N_ENT);
  localparam int WOF_W = $clog2(N_WORDS);
  localparam int REG_W = $clog2(N_REGS);
  localparam int MEM_N = N_ENT * N_WORDS;

  ent_state_t          st      [N_ENT];
  logic [LINE_W-1:0]   line_q  [N_ENT];
  logic [N_WORDS-1:0]  wmask   [N_ENT];
  logic [REG_W-1:0]    wreg    [N_ENT][N_WORDS];
  logic [DATA_W-1:0]   line_mem[MEM_N];

  logic [N_ENT-1:0] hit_vec, free_vec, filled_vec;
  logic [TAG_W-1:0] hit_idx, free_idx, dr_ent;
  logic             hit_any, free_any, dr_any;
  logic [WOF_W-1:0] dr_word;
  logic             dr_word_any;
  logic [N_WORDS-1:0] dr_mask;
  logic             dr_last;
  logic [REG_W-1:0] dr_reg;
  logic             word_taken, accept, do_alloc, req_pop;

  always_comb begin
    for (int e = 0; e < N_ENT; e++) begin
      hit_vec[e]    = (st[e] == ENT_WAIT) && (line_q[e] == miss_line);
      free_vec[e]   = (st[e] == ENT_FREE);
      filled_vec[e] = (st[e] == ENT_FILLED);
    end
  end

  mshr_prio_enc #(.W(N_ENT)) u_hit  (.vec(hit_vec),    .idx(hit_idx),  .any(hit_any));
  mshr_prio_enc #(.W(N_ENT)) u_free (.vec(free_vec),   .idx(free_idx), .any(free_any));
  mshr_prio_enc #(.W(N_ENT)) u_dent (.vec(filled_vec), .idx(dr_ent),   .any(dr_any));

  assign dr_mask = wmask[dr_ent];
  mshr_prio_enc #(.W(N_WORDS)) u_dword (.vec(dr_mask), .idx(dr_word), .any(dr_word_any));

  always_comb begin
    dr_last = ((dr_mask & ~(N_WORDS'(1) << dr_word)) == '0);
    dr_reg  = wreg[dr_ent][dr_word];
  end

  // Admission of a miss
  always_comb begin
    word_taken = hit_any && wmask[hit_idx][miss_word];
    miss_stall = miss_valid &&
                 (reg_busy[miss_rd] || word_taken || (!hit_any && !free_any));
    accept     = miss_valid && !miss_stall;
    do_alloc   = accept && !hit_any;
  end

  // Entry state
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < N_ENT; e++) begin
        st[e]    <= ENT_FREE;
        wmask[e] <= '0;
      end
    end else begin
      for (int e = 0; e < N_ENT; e++) begin
        if (do_alloc && free_idx == TAG_W'(e)) begin
          st[e]                <= ENT_WAIT;
          wmask[e]             <= N_WORDS'(1) << miss_word;
        end
        if (accept && hit_any && hit_idx == TAG_W'(e)) begin
          wmask[e][miss_word]  <= 1'b1;
        end
        if (fill_valid && fill_tag == TAG_W'(e) && st[e] == ENT_WAIT) begin
          st[e]                <= ENT_FILLED;
        end
        if (dr_any && dr_word_any && dr_ent == TAG_W'(e)) begin
          wmask[e][dr_word]    <= 1'b0;
          if (dr_last) st[e]   <= ENT_FREE;
        end
      end
    end
  end

  // Line addresses and waiting registers (no reset needed)
  always_ff @(posedge clk) begin
    for (int e = 0; e < N_ENT; e++) begin
      if (do_alloc && free_idx == TAG_W'(e)) line_q[e] <= miss_line;
      if (accept && ((do_alloc && free_idx == TAG_W'(e)) ||
                     (hit_any && hit_idx == TAG_W'(e))))
        wreg[e][miss_word] <= miss_rd;
    end
  end

  // Fill data storage, word-addressed as {entry, word}
  always_ff @(posedge clk) begin
    if (fill_valid) begin
      for (int w = 0; w < N_WORDS; w++)
        line_mem[{fill_tag, WOF_W'(w)}] <= fill_data[w*DATA_W +: DATA_W];
    end
  end

  // Registered write-back port
  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid <= 1'b0;
      wb_rd    <= '0;
      wb_data  <= '0;
    end else begin
      wb_valid <= dr_any && dr_word_any;
      wb_rd    <= dr_reg;
      wb_data  <= line_mem[{dr_ent, dr_word}];
    end
  end

  mshr_scoreboard #(.N_REGS(N_REGS)) u_sb (
    .clk     (clk),
    .rst     (rst),
    .set_en  (accept),
    .set_idx (miss_rd),
    .clr_en  (dr_any && dr_word_any),
    .clr_idx (dr_reg),
    .busy    (reg_busy)
  );

  assign req_pop = req_valid && req_ready;

  mshr_order_fifo #(.DEPTH(N_ENT), .DW(TAG_W)) u_order (
    .clk       (clk),
    .rst       (rst),
    .push      (do_alloc),
    .push_data (free_idx),
    .pop       (req_pop),
    .not_empty (req_valid),
    .head      (req_tag)
  );

  assign req_line = line_q[req_tag];
endmodule

// File: rtl/mshr_file_chk.sv
module mshr_file_chk #(
  parameter int N_ENT  = 4,
  parameter int N_REGS = 32,
  parameter int LINE_W = 28
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      miss_valid,
  input logic [$clog2(N_REGS)-1:0] miss_rd,
  input logic                      miss_stall,
  input logic [N_REGS-1:0]         reg_busy,
  input logic                      req_valid,
  input logic                      req_ready,
  input logic [LINE_W-1:0]         req_line,
  input logic [$clog2(N_ENT)-1:0]  req_tag,
  input logic                      wb_valid,
  input logic [$clog2(N_REGS)-1:0] wb_rd
);
  p_busy_dest_stalls_r5: assert property (@(posedge clk) disable iff (rst)
    (miss_valid && reg_busy[miss_rd]) |-> miss_stall);

  p_accept_marks_busy_r1: assert property (@(posedge clk) disable iff (rst)
    (miss_valid && !miss_stall) |=> reg_busy[$past(miss_rd)]);

  p_stall_leaves_busy_r10: assert property (@(posedge clk) disable iff (rst)
    (miss_valid && miss_stall && !reg_busy[miss_rd] && !wb_valid)
      |=> !reg_busy[$past(miss_rd)]);

  p_wb_clears_busy_r8: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> !reg_busy[wb_rd]);

  p_req_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_tag) && $stable(req_line)));
endmodule

bind mshr_file mshr_file_chk #(
  .N_ENT  (N_ENT),
  .N_REGS (N_REGS),
  .LINE_W (LINE_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .miss_valid (miss_valid),
  .miss_rd    (miss_rd),
  .miss_stall (miss_stall),
  .reg_busy   (reg_busy),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_line   (req_line),
  .req_tag    (req_tag),
  .wb_valid   (wb_valid),
  .wb_rd      (wb_rd)
);

// File: tb/mshr_file_test.sv
`timescale 1ns/1ps
module mshr_file_test;
  localparam int N_ENT = 4, N_WORDS = 4, N_REGS = 32, LINE_W = 28, DATA_W = 32;
  localparam int TAG_W = $clog2(N_ENT), WOF_W = $clog2(N_WORDS), REG_W = $clog2(N_REGS);

  logic clk = 0, rst = 1;
  logic miss_valid = 0;
  logic [LINE_W-1:0] miss_line = '0;
  logic [WOF_W-1:0] miss_word = '0;
  logic [REG_W-1:0] miss_rd = '0;
  logic miss_stall;
  logic [N_REGS-1:0] reg_busy;
  logic req_valid, req_ready = 0;
  logic [LINE_W-1:0] req_line;
  logic [TAG_W-1:0] req_tag;
  logic fill_valid = 0;
  logic [TAG_W-1:0] fill_tag = '0;
  logic [N_WORDS*DATA_W-1:0] fill_data = '0;
  logic wb_valid;
  logic [REG_W-1:0] wb_rd;
  logic [DATA_W-1:0] wb_data;

  mshr_file #(.N_ENT(N_ENT), .N_WORDS(N_WORDS), .N_REGS(N_REGS),
              .LINE_W(LINE_W), .DATA_W(DATA_W)) uut (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [LINE_W+TAG_W-1:0] exp_req[$];
  logic [REG_W+DATA_W-1:0] exp_wb[$];
  bit               m_wait [N_ENT][N_WORDS];
  logic [REG_W-1:0] m_rd   [N_ENT][N_WORDS];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  // Monitors: sample at the falling edge
  always @(negedge clk) begin
    if (!rst && req_valid && req_ready) begin
      if (exp_req.size() == 0) check(0, "R2/R10 unexpected request", {req_line, req_tag}, 0);
      else begin
        logic [LINE_W+TAG_W-1:0] e;
        e = exp_req.pop_front();
        check({req_line, req_tag} == e, "R6 request order", {req_line, req_tag}, e);
      end
    end
    if (!rst && wb_valid) begin
      if (exp_wb.size() == 0) check(0, "R7 unexpected write-back", {wb_rd, wb_data}, 0);
      else begin
        logic [REG_W+DATA_W-1:0] e;
        e = exp_wb.pop_front();
        check({wb_rd, wb_data} == e, "R7 write-back register/data", {wb_rd, wb_data}, e);
      end
    end
  end

  task automatic do_miss(input logic [LINE_W-1:0] ln, input int wd, input int rd,
                         input bit exp_stall, input bit exp_new, input int tag, input string req);
    @(posedge clk); #1;
    miss_valid = 1; miss_line = ln; miss_word = WOF_W'(wd); miss_rd = REG_W'(rd);
    @(negedge clk);
    check(miss_stall == exp_stall, req, miss_stall, exp_stall);
    if (!exp_stall) begin
      if (exp_new) exp_req.push_back({ln, TAG_W'(tag)});
      m_wait[tag][wd] = 1;
      m_rd[tag][wd]   = REG_W'(rd);
    end
    @(posedge clk); #1;
    miss_valid = 0;
  endtask

  function automatic logic [DATA_W-1:0] fword(int tag, int w, int seed);
    return DATA_W'(32'hC0DE_0000 + seed * 256 + tag * 16 + w);
  endfunction

  task automatic do_fill(input int tag, input int seed);
    @(posedge clk); #1;
    fill_valid = 1; fill_tag = TAG_W'(tag);
    for (int w = 0; w < N_WORDS; w++) begin
      fill_data[w*DATA_W +: DATA_W] = fword(tag, w, seed);
      if (m_wait[tag][w]) begin
        exp_wb.push_back({m_rd[tag][w], fword(tag, w, seed)});
        m_wait[tag][w] = 0;
      end
    end
    @(posedge clk); #1;
    fill_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  localparam logic [LINE_W-1:0] LA = 28'h00A_1000, LB = 28'h00B_2000,
    LC = 28'h00C_3000, LD = 28'h00D_4000, LE = 28'h00E_5000;

  initial begin
    for (int t = 0; t < N_ENT; t++)
      for (int w = 0; w < N_WORDS; w++) begin m_wait[t][w] = 0; m_rd[t][w] = '0; end
    idle(3);
    rst = 0;
    @(negedge clk);
    check(reg_busy == '0, "R9 busy after reset", reg_busy, 0);
    check(req_valid == 0, "R9 request after reset", req_valid, 0);
    check(wb_valid == 0, "R9 write-back after reset", wb_valid, 0);

    do_miss(LA, 1, 5, 0, 1, 0, "R1 first miss accepted");
    @(negedge clk);
    check(reg_busy[5] == 1, "R1 destination busy", reg_busy[5], 1);
    do_miss(LA, 3, 7, 0, 0, 0, "R2 merge accepted");
    do_miss(LA, 1, 9, 1, 0, 0, "R3 word already waiting");
    @(negedge clk);
    check(reg_busy[9] == 0, "R10 stalled miss leaves register", reg_busy[9], 0);
    do_miss(LB, 0, 5, 1, 0, 0, "R5 busy destination");
    do_miss(LB, 0, 6, 0, 1, 1, "R1 second line");
    do_miss(LC, 2, 8, 0, 1, 2, "R1 third line");
    do_miss(LD, 0, 10, 0, 1, 3, "R1 fourth line");
    do_miss(LE, 0, 11, 1, 0, 0, "R4 all entries busy");
    @(negedge clk);
    check(reg_busy[11] == 0, "R10 full stall leaves register", reg_busy[11], 0);
    check(req_valid == 1 && req_tag == 0, "R6 head held while not ready", {req_valid, req_tag}, {1'b1, 2'd0});
    @(posedge clk); #1;
    req_ready = 1;
    idle(6);
    check(exp_req.size() == 0, "R6 all requests issued", exp_req.size(), 0);

    do_fill(2, 1);
    idle(6);
    check(reg_busy[8] == 0, "R8 busy cleared after write-back", reg_busy[8], 0);
    do_fill(0, 2);
    idle(6);
    check(reg_busy[5] == 0 && reg_busy[7] == 0, "R8 merged registers cleared", {reg_busy[7], reg_busy[5]}, 0);

    do_miss(LE, 0, 11, 0, 1, 0, "R8 freed entry reused");
    do_miss(LE, 1, 12, 0, 0, 0, "R2 merge word 1");
    do_miss(LE, 2, 13, 0, 0, 0, "R2 merge word 2");
    do_miss(LE, 3, 14, 0, 0, 0, "R2 merge word 3");
    idle(3);
    check(exp_req.size() == 0, "R2 merges add no request", exp_req.size(), 0);
    do_fill(0, 3);
    begin
      int cnt = 0, run = 0, best = 0;
      for (int i = 0; i < 7; i++) begin
        @(negedge clk);
        if (wb_valid) begin cnt++; run++; if (run > best) best = run; end
        else run = 0;
      end
      check(cnt == 4 && best == 4, "R7 one write-back per consecutive cycle", best, 4);
    end
    do_fill(1, 4);
    idle(4);
    do_fill(3, 5);
    idle(4);
    @(negedge clk);
    check(reg_busy == '0, "R8 nothing busy after all fills", reg_busy, 0);
    check(exp_wb.size() == 0, "R7 all write-backs seen", exp_wb.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule